// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Timed Write Cycle

This block is the target side of a two-wire serial bus (I2C) in front of a small byte-wide storage array held in on-chip registers. A system clock oversamples the bus clock and data lines. The block pulls the data line low through an output-enable signal, so the pad behaves as open drain. A master writes one or more bytes into a page, reads back from the current position, or moves the position and then reads from it.

Data bytes written in one transfer collect in a page buffer. They reach the array only when a STOP ends the write. That STOP also starts an internal write cycle of fixed length, timed by a counter. For the whole cycle the block ignores the bus. A master can therefore repeat START plus address until it receives an acknowledge, which tells it the cycle has finished.

Top module: `i2c_ee_slave`

## Requirements
- R1: After a synchronous reset the block releases SDA (sda_oe = 0), is not in a write cycle, and answers the next START and matching address with an acknowledge.
- R2: The first byte after START is sent MSB first. Bits 7..1 are the device address and bit 0 is R/W (1 = read). The block pulls SDA low in the ninth clock only when bits 7..1 equal DEV_ADDR; for any other address it leaves SDA released.
- R3: In a write (R/W = 0), the byte after the address loads the word address. Each following data byte is stored at the current position, and the position then advances. Every byte is acknowledged.
- R4: During a write only the low PAGE_BITS bits of the position advance, and the upper bits never change. A write of more than 2^PAGE_BITS bytes therefore wraps to the start of the same page, and the later bytes overwrite the earlier ones.
- R5: Buffered data reaches the array only when a STOP ends a write that carried at least one data byte. A repeated START aborts the write, commits nothing and starts no write cycle.
- R6: For WR_CYCLES clocks after a committing STOP, the block ignores START and never drives SDA, so polling addresses get no acknowledge. After that time it acknowledges again.
- R7: A random read works as follows: a write-mode address, one word-address byte, a repeated START, then a read-mode address. It returns the byte stored at that word address.
- R8: A read started without a word address returns the byte one past the location most recently read or written, and each byte sent advances the position by one.
- R9: When the master acknowledges a read byte, the block sends the next sequential byte. When the master does not acknowledge, the block stops driving SDA and waits for the next START.
- R10: The block samples SDA on the rising edge of SCL and changes sda_oe only while SCL is low. It releases SDA once the acknowledge clock of a write byte has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The hardest situation to reach is the moment the write cycle ends. Only bus traffic can observe it, and during the cycle the block answers nothing at all. The bench commits a page, then polls with START plus write address back to back. It requires the first poll to be refused and a later one to be acknowledged. A page write of more than sixteen bytes starting near the end of a page checks the wrap. An aborted write followed by an immediate acknowledged address shows that no write cycle was started and no data was stored.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK
  } ee_state_t;

  typedef enum logic [1:0] {
    PH_DEV, PH_WORD, PH_DATA
  } ee_phase_t;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int   W       = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= {W{RST_VAL}};
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_ee_array.sv
module i2c_ee_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
  import i2c_ee_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         AW          = 8,
  parameter int         PAGE_BITS   = 4,
  parameter int         WR_CYCLES   = 2000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int PAGE = 1 << PAGE_BITS;
  localparam int BW   = $clog2(WR_CYCLES + 1);
  localparam int HW   = AW - PAGE_BITS;

  // synchronized bus lines and edge events
  logic [1:0] bus_s;
  logic       scl_s, sda_s, scl_q, sda_q;
  logic       scl_rise, scl_fall, start_det, stop_det;

  i2c_ee_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  // protocol state
  ee_state_t          st;
  ee_phase_t          ph;
  logic [3:0]         cnt;
  logic [BYTE_W-1:0]  shreg, tx_sh, rd_q;
  logic               rw, mack_ok;
  logic [AW-1:0]      ptr;
  logic [PAGE-1:0]    vmask;
  logic [BYTE_W-1:0]  pbuf [PAGE];
  logic [BW-1:0]      busy_cnt;
  logic               busy, cact;
  logic [PAGE_BITS-1:0] cidx;
  logic [HW-1:0]      page_q;
  logic               byte_done, data_strobe, mem_we;

  assign busy        = (busy_cnt != '0);
  assign byte_done   = !busy && !stop_det && !start_det && (st == ST_RX) &&
                       scl_fall && (cnt == 4'd8);
  assign data_strobe = byte_done && (ph == PH_DATA);
  assign mem_we      = cact && vmask[cidx];

  always_ff @(posedge clk) begin
    if (data_strobe) pbuf[ptr[PAGE_BITS-1:0]] <= shreg;
  end

  i2c_ee_array #(.AW(AW), .DW(BYTE_W)) u_array (
    .clk(clk), .we(mem_we), .waddr({page_q, cidx}), .wdata(pbuf[cidx]),
    .raddr(ptr), .rdata(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  ph <= PH_DEV;  cnt <= '0;  shreg <= '0;  tx_sh <= '0;
      rw <= 1'b0;  mack_ok <= 1'b0;  ptr <= '0;  sda_oe <= 1'b0;  vmask <= '0;
      busy_cnt <= '0;  cact <= 1'b0;  cidx <= '0;  page_q <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (cact) begin
        cidx <= cidx + 1'b1;
        if (cidx == PAGE_BITS'(PAGE - 1)) cact <= 1'b0;
      end

      if (!busy && stop_det) begin
        st     <= ST_IDLE;
        ph     <= PH_DEV;
        sda_oe <= 1'b0;
        if (ph == PH_DATA && vmask != '0) begin
          cact     <= 1'b1;
          cidx     <= '0;
          page_q   <= ptr[AW-1:PAGE_BITS];
          busy_cnt <= BW'(WR_CYCLES);
        end
      end else if (!busy && start_det) begin
        st     <= ST_RX;
        ph     <= PH_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
        vmask  <= '0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (byte_done) begin
              cnt <= '0;
              unique case (ph)
                PH_DEV: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    rw     <= shreg[0];
                    sda_oe <= 1'b1;
                    st     <= ST_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                PH_WORD: begin
                  ptr    <= shreg;
                  ph     <= PH_DATA;
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                end
                default: begin
                  vmask[ptr[PAGE_BITS-1:0]] <= 1'b1;
                  ptr    <= {ptr[AW-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + PAGE_BITS'(1)};
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (ph == PH_DEV && rw) begin
                tx_sh  <= rd_q;
                sda_oe <= ~rd_q[7];
                ptr    <= ptr + 1'b1;
                cnt    <= '0;
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
                if (ph == PH_DEV) ph <= PH_WORD;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe  <= 1'b0;
                mack_ok <= 1'b0;
                st      <= ST_MACK;
              end else begin
                sda_oe <= ~tx_sh[6];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_s) st <= ST_IDLE;
              else       mack_ok <= 1'b1;
            end else if (scl_fall && mack_ok) begin
              tx_sh  <= rd_q;
              sda_oe <= ~rd_q[7];
              ptr    <= ptr + 1'b1;
              cnt    <= '0;
              st     <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // checks beside the logic they guard
  assert_page_hi_fixed_R4: assert property (@(posedge clk) disable iff (rst)
    data_strobe |=> ptr[AW-1:PAGE_BITS] == $past(ptr[AW-1:PAGE_BITS]));

  assert_busy_from_stop_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det));

  assert_mem_we_in_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  assert_quiet_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!sda_oe && st == ST_IDLE));

  assert_oe_change_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);
endmodule

// File: tb/i2c_ee_slave_tb.sv
`timescale 1ns/1ps
module i2c_ee_slave_tb_top;
  localparam logic [6:0] DEV = 7'h50;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [256];
  logic [7:0] bptr;

  always #2.5 clk = ~clk;

  i2c_ee_slave #(.DEV_ADDR(DEV)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(2);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    ack = !a;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(!mack);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda released after reset", sda_oe, 0);
  endtask

  task automatic t_bad_addr();
    bit ack;
    bus_start();
    send_byte({7'h21, 1'b0}, ack);
    chk(!ack, "R2 foreign address not acknowledged", ack, 0);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack, "R1 R2 own address acknowledged", ack, 1);
    bus_stop();
  endtask

  task automatic t_page_write(input logic [7:0] addr, input int n, input logic [7:0] base);
    bit ack, all_ack = 1'b1;
    bus_start();
    send_byte({DEV, 1'b0}, ack); all_ack &= ack;
    send_byte(addr, ack);        all_ack &= ack;
    bptr = addr;
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i), ack);
      all_ack &= ack;
      exp_mem[bptr] = base + 8'(i);
      bptr = {bptr[7:4], bptr[3:0] + 4'd1};
    end
    chk(all_ack, "R3 every write byte acknowledged", all_ack, 1);
    chk(sda_line == 1'b1, "R10 SDA released after acknowledge clock", sda_line, 1);
    bus_stop();
  endtask

  task automatic t_poll();
    bit ack = 1'b0;
    int nacks = 0;
    bit first_nack = 1'b0;
    for (int k = 0; k < 40 && !ack; k++) begin
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      if (k == 0) first_nack = !ack;
      if (!ack) nacks++;
      bus_stop();
    end
    chk(first_nack, "R6 no acknowledge during write cycle", first_nack, 1);
    chk(ack, "R6 acknowledge returns after write cycle", ack, 1);
  endtask

  task automatic t_random_read(input logic [7:0] addr, input int n, input string tag);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(addr, ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk(ack, {tag, " read address acknowledged"}, ack, 1);
    bptr = addr;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d === exp_mem[bptr], tag, d, exp_mem[bptr]);
      bptr = bptr + 8'd1;
    end
    chk(sda_line == 1'b1, "R9 SDA released after master NACK", sda_line, 1);
    bus_stop();
  endtask

  task automatic t_current_read(input int n, input string tag);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d === exp_mem[bptr], tag, d, exp_mem[bptr]);
      bptr = bptr + 8'd1;
    end
    chk(sda_line == 1'b1, "R9 SDA released after master NACK", sda_line, 1);
    bus_stop();
  endtask

  task automatic t_abort();
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h22, ack);
    send_byte(8'h55, ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, d);
    chk(d === exp_mem[8'h23], "R8 read after aborted write", d, exp_mem[8'h23]);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack, "R5 no write cycle after aborted write", ack, 1);
    bus_stop();
    t_random_read(8'h22, 1, "R5 aborted byte not stored");
  endtask

  initial begin
    repeat (20) @(posedge clk);
    #1 rst = 1'b0;
    wq(2);
    t_reset();
    t_bad_addr();
    t_page_write(8'h22, 4, 8'hA0);
    t_poll();
    t_random_read(8'h22, 1, "R7 random read");
    t_current_read(1, "R8 current address read");
    t_current_read(2, "R9 sequential read");
    t_page_write(8'h3E, 18, 8'h10);
    t_poll();
    t_random_read(8'h3E, 2, "R4 wrapped bytes overwrite");
    t_random_read(8'h30, 3, "R4 page start after wrap");
    t_abort();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule